// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block guards a small configuration space behind a pair of byte ports: an index port at the base address (`addr_i = 0`) and a data port at base+1 (`addr_i = 1`). Out of reset the space is locked. Software unlocks it by writing a four-byte key to the index port. The last byte of the key depends on a strap input that tells which of two base ports the block is mapped at. While the space is unlocked, an index write selects a register and data accesses read or write that register. A write to the lock register closes the space again.

The space holds the chip identity bytes, a logical-device selector, and a global flash-decode control byte, which drives segment enables and related flags. It also holds a flash-controller I/O base. That base can only be reached while the flash logical device is selected. The controller drives the lock state, the selected device, the flash base and the decode control fields straight to the rest of the chip. Read data is combinational from the port address and the current state.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: With `strap_alt_i = 0` (base port 0x2E), index-port writes of 0x87, 0x01, 0x55, 0x55 in that order raise `unlocked_o` on the clock edge that accepts the fourth write.
- R2: With `strap_alt_i = 1` (base port 0x4E), the fourth key byte is 0xAA. The sequence 0x87, 0x01, 0x55, 0x55 leaves the block locked, and 0x87, 0x01, 0x55, 0xAA unlocks it.
- R3: While locked, an index-port write that does not match the expected key byte restarts matching. If that byte is 0x87, it is taken as the first key byte. Otherwise the next byte must be 0x87.
- R4: While locked, data-port writes change no register or output, and reads of either port return 0xFF.
- R5: While unlocked, a data write to index 0x02 with bit 1 set returns the block to the locked state. A write there with bit 1 clear has no effect. Index 0x02 reads 0x00.
- R6: Indexes 0x20, 0x21 and 0x22 read the chip ID high byte (default 0x87), the chip ID low byte (default 0x16) and the version (default 0x01). Writes to them have no effect. Unmapped indexes read 0xFF.
- R7: While unlocked, index 0x07 is a read/write logical-device selector, driven on `ldn_o`. An index-port read returns the current index.
- R8: Indexes 0x64 (flash base high byte) and 0x65 (flash base low byte) are reachable only when the selector equals 7. Otherwise they read 0xFF and writes to them are ignored.
- R9: The flash base is held as a multiple of 8 below 0x1000. The high byte keeps bits 3:0, and the low byte keeps bits 7:3, with bits 2:0 reading 0. `flash_base_o` shows the 16-bit value.
- R10: Index 0x24 is the global flash-decode control. Bit 0 drives `suspend_o`, bits 3:1 drive `seg_en_o`, bit 4 drives `host_wr_en_o`, and bit 5 drives `pin_sel_o`. Bits 7:6 read 0.
- R11: After reset the block is locked, the index and selector are 0x00, index 0x24 is 0x00, and the flash base is 0x0820.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_alt_i | input | 1 | Base-port strap: 0 selects base 0x2E, 1 selects base 0x4E |
| wr_i | input | 1 | Byte write strobe, one cycle per write |
| addr_i | input | 1 | Port select: 0 index port, 1 data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed port |
| unlocked_o | output | 1 | Configuration space is open |
| ldn_o | output | 8 | Selected logical device |
| flash_base_o | output | 16 | Flash controller I/O base |
| suspend_o | output | 1 | Suspend flag, bit 0 of index 0x24 |
| seg_en_o | output | 3 | Flash segment enables, bits 3:1 of index 0x24 |
| host_wr_en_o | output | 1 | Host write to flash enabled, bit 4 of index 0x24 |
| pin_sel_o | output | 1 | Flash pin option, bit 5 of index 0x24 |

## Verification
A key-stage counter stuck or advanced wrongly shows up as a missed or premature rise of `unlocked_o`. The bench sees this within one write of the fourth key byte, and the near-miss and restart sequences push the counter through every stage. A wrong lock flag appears on the next data read as 0xFF where a register value was due, or the other way round. A bad selector gate or base mask appears on the next readback of 0x64/0x65 and on `flash_base_o` in the cycle after the write.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
  localparam int unsigned BW = 8;

  localparam logic [BW-1:0] KEY_B0      = 8'h87;
  localparam logic [BW-1:0] KEY_B1      = 8'h01;
  localparam logic [BW-1:0] KEY_B2      = 8'h55;
  localparam logic [BW-1:0] KEY_LAST_LO = 8'h55;  // strap 0: base 0x2E
  localparam logic [BW-1:0] KEY_LAST_HI = 8'hAA;  // strap 1: base 0x4E

  localparam logic [BW-1:0] IX_LOCK   = 8'h02;
  localparam logic [BW-1:0] IX_LDN    = 8'h07;
  localparam logic [BW-1:0] IX_ID_HI  = 8'h20;
  localparam logic [BW-1:0] IX_ID_LO  = 8'h21;
  localparam logic [BW-1:0] IX_VER    = 8'h22;
  localparam logic [BW-1:0] IX_GCTL   = 8'h24;
  localparam logic [BW-1:0] IX_FB_HI  = 8'h64;
  localparam logic [BW-1:0] IX_FB_LO  = 8'h65;

  typedef enum logic [1:0] {KS_B0, KS_B1, KS_B2, KS_B3} key_stage_e;
endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
  import cfg_unlock_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_alt_i,
  input  logic          wr_i,
  input  logic [BW-1:0] byte_i,
  input  logic          relock_i,
  output logic          unlocked_o
);
  key_stage_e    stage_q;
  logic          unlocked_q;
  logic [BW-1:0] exp_byte, last_key;

  assign last_key = strap_alt_i ? KEY_LAST_HI : KEY_LAST_LO;

  always_comb begin
    unique case (stage_q)
      KS_B0:   exp_byte = KEY_B0;
      KS_B1:   exp_byte = KEY_B1;
      KS_B2:   exp_byte = KEY_B2;
      default: exp_byte = last_key;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q    <= KS_B0;
      unlocked_q <= 1'b0;
    end else if (relock_i) begin
      stage_q    <= KS_B0;
      unlocked_q <= 1'b0;
    end else if (wr_i && !unlocked_q) begin
      if (byte_i == exp_byte) begin
        unique case (stage_q)
          KS_B0:   stage_q <= KS_B1;
          KS_B1:   stage_q <= KS_B2;
          KS_B2:   stage_q <= KS_B3;
          default: begin
            stage_q    <= KS_B0;
            unlocked_q <= 1'b1;
          end
        endcase
      end else begin
        // a stray 0x87 counts as a fresh first byte
        stage_q <= (byte_i == KEY_B0) ? KS_B1 : KS_B0;
      end
    end
  end

  assign unlocked_o = unlocked_q;

  // R1 R2: unlocking only follows a write of the strap-selected last byte
  assert_unlock_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_q) |-> ($past(wr_i) && ($past(byte_i) == $past(last_key))));

  // R3: a mismatch that is not 0x87 leaves matching at the first byte
  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !unlocked_q && !relock_i && byte_i != exp_byte && byte_i != KEY_B0)
      |=> (stage_q == KS_B0 && !unlocked_q));

  // R5: relock closes the space on the next cycle
  assert_relock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> !unlocked_q);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_unlock_pkg::*;
#(
  parameter logic [15:0]   CHIP_ID        = 16'h8716,
  parameter logic [BW-1:0] CHIP_VER       = 8'h01,
  parameter logic [BW-1:0] FLASH_LDN      = 8'h07,
  parameter logic [15:0]   FLASH_BASE_RST = 16'h0820
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_wr_i,
  input  logic          data_wr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] idx_o,
  output logic [BW-1:0] data_rd_o,
  output logic          relock_o,
  output logic [BW-1:0] ldn_o,
  output logic [15:0]   flash_base_o,
  output logic [BW-1:0] gctl_o
);
  localparam int unsigned HI_W  = 4;  // base stays below 0x1000
  localparam int unsigned ALN   = 3;  // base is a multiple of 8
  localparam int unsigned LO_W  = BW - ALN;
  localparam int unsigned GCTL_W = 6;

  logic [BW-1:0]     idx_q, ldn_q;
  logic [GCTL_W-1:0] gctl_q;
  logic [HI_W-1:0]   fb_hi_q;
  logic [LO_W-1:0]   fb_lo_q;
  logic              flash_sel;

  assign flash_sel = (ldn_q == FLASH_LDN);
  assign relock_o  = data_wr_i && (idx_q == IX_LOCK) && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      ldn_q   <= '0;
      gctl_q  <= '0;
      fb_hi_q <= FLASH_BASE_RST[BW+HI_W-1:BW];
      fb_lo_q <= FLASH_BASE_RST[BW-1:ALN];
    end else begin
      if (idx_wr_i) idx_q <= wdata_i;
      if (data_wr_i) begin
        unique case (idx_q)
          IX_LDN:   ldn_q  <= wdata_i;
          IX_GCTL:  gctl_q <= wdata_i[GCTL_W-1:0];
          IX_FB_HI: if (flash_sel) fb_hi_q <= wdata_i[HI_W-1:0];
          IX_FB_LO: if (flash_sel) fb_lo_q <= wdata_i[BW-1:ALN];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (idx_q)
      IX_LOCK:  data_rd_o = '0;
      IX_LDN:   data_rd_o = ldn_q;
      IX_ID_HI: data_rd_o = CHIP_ID[15:8];
      IX_ID_LO: data_rd_o = CHIP_ID[7:0];
      IX_VER:   data_rd_o = CHIP_VER;
      IX_GCTL:  data_rd_o = {{(BW-GCTL_W){1'b0}}, gctl_q};
      IX_FB_HI: data_rd_o = flash_sel ? {{(BW-HI_W){1'b0}}, fb_hi_q} : '1;
      IX_FB_LO: data_rd_o = flash_sel ? {fb_lo_q, {ALN{1'b0}}} : '1;
      default:  data_rd_o = '1;
    endcase
  end

  assign idx_o        = idx_q;
  assign ldn_o        = ldn_q;
  assign gctl_o       = {{(BW-GCTL_W){1'b0}}, gctl_q};
  assign flash_base_o = {{(16-BW-HI_W){1'b0}}, fb_hi_q, fb_lo_q, {ALN{1'b0}}};

  // R8: base bytes are untouched unless the flash device is selected
  assert_fb_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !flash_sel) |=> $stable(flash_base_o));
endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
  import cfg_unlock_pkg::*;
#(
  parameter logic [15:0] CHIP_ID        = 16'h8716,
  parameter logic [7:0]  CHIP_VER       = 8'h01,
  parameter logic [7:0]  FLASH_LDN      = 8'h07,
  parameter logic [15:0] FLASH_BASE_RST = 16'h0820
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        strap_alt_i,
  input  logic        wr_i,
  input  logic        addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        unlocked_o,
  output logic [7:0]  ldn_o,
  output logic [15:0] flash_base_o,
  output logic        suspend_o,
  output logic [2:0]  seg_en_o,
  output logic        host_wr_en_o,
  output logic        pin_sel_o
);
  logic          idx_wr, data_wr, relock, unlocked;
  logic [BW-1:0] idx, data_rd, gctl;

  assign idx_wr  = wr_i && !addr_i;
  assign data_wr = wr_i && addr_i;

  cfg_key_match u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_alt_i (strap_alt_i),
    .wr_i        (idx_wr),
    .byte_i      (wdata_i),
    .relock_i    (relock),
    .unlocked_o  (unlocked)
  );

  cfg_regfile #(
    .CHIP_ID        (CHIP_ID),
    .CHIP_VER       (CHIP_VER),
    .FLASH_LDN      (FLASH_LDN),
    .FLASH_BASE_RST (FLASH_BASE_RST)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_wr_i     (idx_wr && unlocked),
    .data_wr_i    (data_wr && unlocked),
    .wdata_i      (wdata_i),
    .idx_o        (idx),
    .data_rd_o    (data_rd),
    .relock_o     (relock),
    .ldn_o        (ldn_o),
    .flash_base_o (flash_base_o),
    .gctl_o       (gctl)
  );

  assign rdata_o      = !unlocked ? 8'hFF : (addr_i ? data_rd : idx);
  assign unlocked_o   = unlocked;
  assign suspend_o    = gctl[0];
  assign seg_en_o     = gctl[3:1];
  assign host_wr_en_o = gctl[4];
  assign pin_sel_o    = gctl[5];

  // R4: locked writes leave every configuration output unchanged
  assert_locked_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && wr_i) |=> ($stable(flash_base_o) && $stable(ldn_o) &&
                               $stable(seg_en_o) && $stable(suspend_o) &&
                               $stable(host_wr_en_o) && $stable(pin_sel_o)));
endmodule

// File: tb/tb_cfg_unlock_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_unlock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic        wr = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        unlocked;
  logic [7:0]  ldn;
  logic [15:0] fbase;
  logic        suspend, host_wr_en, pin_sel;
  logic [2:0]  seg_en;

  int checks = 0;
  int fails  = 0;
  logic rd_req = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cfg_unlock_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_alt_i(strap_alt), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .unlocked_o(unlocked),
    .ldn_o(ldn), .flash_base_o(fbase), .suspend_o(suspend), .seg_en_o(seg_en),
    .host_wr_en_o(host_wr_en), .pin_sel_o(pin_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard at the falling edge
  always @(negedge clk) begin
    if (rd_req) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic wr_port(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_port(input logic a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    addr = a; rd_req = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic key(input logic [7:0] b3);
    wr_port(1'b0, 8'h87); wr_port(1'b0, 8'h01);
    wr_port(1'b0, 8'h55); wr_port(1'b0, b3);
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr_port(1'b0, ix); wr_port(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    wr_port(1'b0, ix); rd_port(1'b1, exp, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    check("R11 locked after reset", unlocked, 0);
    check("R11 ldn reset", ldn, 0);
    check("R11 flash base reset", fbase, 16'h0820);
    check("R11 gctl outputs reset", {suspend, seg_en, host_wr_en, pin_sel}, 0);
    // R4 locked behaviour
    rd_port(1'b1, 8'hFF, "R4 locked data read");
    rd_port(1'b0, 8'hFF, "R4 locked index read");
    wr_port(1'b1, 8'h33);
    check("R4 locked data write ignored", fbase, 16'h0820);
    check("R4 still locked", unlocked, 0);
    // R3 broken sequence
    wr_port(1'b0, 8'h87); wr_port(1'b0, 8'h01); wr_port(1'b0, 8'h00);
    wr_port(1'b0, 8'h55);
    check("R3 broken key stays locked", unlocked, 0);
    // R1 unlock with strap 0
    key(8'h55);
    check("R1 unlocked after key", unlocked, 1);
    // R6 identity
    reg_rd(8'h20, 8'h87, "R6 id high");
    reg_rd(8'h21, 8'h16, "R6 id low");
    reg_rd(8'h22, 8'h01, "R6 version");
    reg_wr(8'h20, 8'h00);
    reg_rd(8'h20, 8'h87, "R6 id write ignored");
    reg_rd(8'h30, 8'hFF, "R6 unmapped reads FF");
    rd_port(1'b0, 8'h30, "R7 index readback");
    // R7 selector
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h07, 8'h05, "R7 ldn readback");
    check("R7 ldn_o", ldn, 8'h05);
    // R8 gate
    reg_rd(8'h64, 8'hFF, "R8 base hi hidden");
    reg_wr(8'h64, 8'h0F);
    check("R8 base write ignored", fbase, 16'h0820);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h64, 8'h08, "R8 base hi visible");
    reg_rd(8'h65, 8'h20, "R8 base lo visible");
    // R9 masking
    reg_wr(8'h64, 8'hFF);
    reg_wr(8'h65, 8'hFF);
    check("R9 base masked", fbase, 16'h0FF8);
    reg_rd(8'h64, 8'h0F, "R9 hi readback");
    reg_rd(8'h65, 8'hF8, "R9 lo readback");
    // R10 decode control
    reg_wr(8'h24, 8'hFF);
    reg_rd(8'h24, 8'h3F, "R10 gctl upper bits zero");
    check("R10 fields all set", {pin_sel, host_wr_en, seg_en, suspend}, 6'h3F);
    reg_wr(8'h24, 8'h2A);
    check("R10 suspend", suspend, 0);
    check("R10 seg_en", seg_en, 3'b101);
    check("R10 host_wr_en", host_wr_en, 0);
    check("R10 pin_sel", pin_sel, 1);
    // R5 relock
    reg_wr(8'h02, 8'h00);
    check("R5 bit1 clear keeps unlocked", unlocked, 1);
    reg_rd(8'h02, 8'h00, "R5 lock reg reads 0");
    reg_wr(8'h02, 8'h02);
    check("R5 relocked", unlocked, 0);
    rd_port(1'b1, 8'hFF, "R5 R4 read after relock");
    check("R5 state kept after relock", fbase, 16'h0FF8);
    // R3 restart on 0x87
    wr_port(1'b0, 8'h87);
    key(8'h55);
    check("R3 0x87 restart unlocks", unlocked, 1);
    reg_wr(8'h02, 8'h02);
    check("R3 relock", unlocked, 0);
    // R2 alternate strap
    strap_alt = 1'b1;
    key(8'h55);
    check("R2 0x55 rejected on alt base", unlocked, 0);
    key(8'hAA);
    check("R2 0xAA unlocks on alt base", unlocked, 1);
    reg_rd(8'h07, 8'h07, "R2 access after alt unlock");
    repeat (3) @(posedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule